// File: doc/BRIEF.md
# Dual Multi-Mode Timer Unit

This block holds two up-counting timers. Each timer is a pair of byte registers, a low count byte and a high count byte. Software reaches the block through a small register bus: an 8-bit address, a write strobe, write data and a combinational read-data path. Two registers are shared by both timers. The mode register holds one 4-bit field per timer. The control register holds a run bit and an overflow flag for each timer.

An internal divide-by-12 prescaler turns the core clock into machine-cycle ticks. A timer that is running advances by one on each tick. Each timer can be set up as a 13-bit cascade counter, a full 16-bit counter or an 8-bit counter with automatic reload. Timer 0 has a fourth setting that splits it into two free 8-bit counters. While timer 0 is split, its high byte takes over timer 1's run bit and flag, and timer 1 counts on every tick with no way to stop it.

The prescaler is a 12-phase cycle, from phase 0 to phase 11. The step from phase 11 back to phase 0 is the tick transition. The count step of each timer follows one of four mode states: CASC13 (field 00), FULL16 (01), RELOAD8 (10) and SPLIT8 (11). A timer leaves one state for another only when software writes the mode register.

Top module: `dual_tmr_unit`

## Requirements
- R1: After reset, all six registers read 0x00 and both flag outputs are low.
- R2: The register addresses are: control 0x88, mode 0x89, timer 0 low 0x8A, timer 1 low 0x8B, timer 0 high 0x8C, timer 1 high 0x8D. Reads of these addresses return the stored value, and reads of any other address return 0x00. Mode bits [1:0] select the timer 0 mode and bits [5:4] select the timer 1 mode. Mode bits [3:2] and [7:6] are stored and read back but have no effect on counting.
- R3: A tick occurs once every 12 clock cycles. A timer advances by exactly one per tick while its run bit is set (control bit 4 for timer 0, bit 6 for timer 1). It holds its value while the run bit is clear.
- R4: In mode 00, only low-byte bits [4:0] count. A step from 31 clears those bits and increments the high byte, and low-byte bits [7:5] are left unchanged. The timer overflows, and sets its flag, when it steps from high 0xFF, low bits 31.
- R5: In mode 01, {high, low} counts as one 16-bit value. A step from 0xFFFF wraps to 0x0000 and sets the timer's flag.
- R6: In mode 10, only the low byte counts. A step from 0xFF loads the low byte from the high byte and sets the flag. The high byte does not change.
- R7: With timer 0 in mode 11, the low byte 0x8A counts under run bit 4 and sets flag bit 5 when it wraps from 0xFF to 0x00. The high byte 0x8C counts under run bit 6 and sets flag bit 7 when it wraps.
- R8: While timer 0 is in mode 11, timer 1 counts in its own mode 00, 01 or 10 on every tick, whatever run bit 6 holds, and its wraps set no flag.
- R9: Timer 1 in mode 11 holds its count and never sets its flag.
- R10: Flag bit 5 (timer 0) and flag bit 7 (timer 1) are set by overflow and stay set until software writes the control register. If an overflow and a control write fall in the same cycle, the set wins. Control bits [3:0] are plain storage. The outputs tf0_flag and tf1_flag show bits 5 and 7.
- R11: If a write to a count byte falls in the same cycle as a tick that would step that byte, the written value is stored and the step is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_wr | input | 1 | Write strobe, one cycle per write |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for sfr_addr, combinational |
| tf0_flag | output | 1 | Timer 0 overflow flag (control bit 5) |
| tf1_flag | output | 1 | Timer 1 overflow flag (control bit 7) |

## Verification
A software write to a count byte and a prescaler tick can fall in the same cycle. The bench first finds the tick phase: it starts timer 0 and polls the low byte until the byte changes. Twelve edges after that change it writes the low byte, so the write lands exactly on the next tick edge. The check is that the written value is held unchanged for the following eleven cycles and steps by one only at the tick after that. A flag set and a control write in the same cycle are covered by a property: every 16-bit wrap must leave the flag set, even when a control write is present.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        TM_CASC13  = 2'd0,
        TM_FULL16  = 2'd1,
        TM_RELOAD8 = 2'd2,
        TM_SPLIT8  = 2'd3
    } tmr_mode_e;

    localparam logic [7:0] ADDR_CTRL = 8'h88;
    localparam logic [7:0] ADDR_MODE = 8'h89;
    localparam logic [7:0] ADDR_T0LO = 8'h8A;
    localparam logic [7:0] ADDR_T1LO = 8'h8B;
    localparam logic [7:0] ADDR_T0HI = 8'h8C;
    localparam logic [7:0] ADDR_T1HI = 8'h8D;

    localparam int CTRL_RUN0  = 4;
    localparam int CTRL_FLAG0 = 5;
    localparam int CTRL_RUN1  = 6;
    localparam int CTRL_FLAG1 = 7;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST_PHASE = CW'(DIV - 1);
    localparam logic [CW-1:0] ONE_PHASE  = CW'(1);

    logic [CW-1:0] phase_q;

    // phase register: 0 .. DIV-1, wrap is the tick transition
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST_PHASE)
            phase_q <= '0;
        else
            phase_q <= phase_q + ONE_PHASE;
    end

    // output decode
    always_comb begin
        tick = (phase_q == LAST_PHASE);
    end
endmodule

// File: rtl/tmr_step.sv
module tmr_step
    import tmr_pkg::*;
#(
    parameter int DW       = 8,
    parameter int NARROW_W = 5,
    parameter bit SPLIT_OK = 1'b1
) (
    input  tmr_mode_e         mode,
    input  logic              step_lo,
    input  logic              step_hi,
    input  logic [DW-1:0]     lo,
    input  logic [DW-1:0]     hi,
    output logic [DW-1:0]     lo_nxt,
    output logic [DW-1:0]     hi_nxt,
    output logic              ovf_lo,
    output logic              ovf_hi
);
    localparam logic [DW-1:0]       ALL1   = '1;
    localparam logic [DW-1:0]       ONE_B  = DW'(1);
    localparam logic [2*DW-1:0]     ONE_W  = (2*DW)'(1);
    localparam logic [NARROW_W-1:0] N_ALL1 = '1;
    localparam logic [NARROW_W-1:0] N_ONE  = NARROW_W'(1);

    always_comb begin
        lo_nxt = lo;
        hi_nxt = hi;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        unique case (mode)
            TM_CASC13: begin
                if (step_lo) begin
                    if (lo[NARROW_W-1:0] == N_ALL1) begin
                        lo_nxt[NARROW_W-1:0] = '0;
                        hi_nxt = hi + ONE_B;
                        ovf_lo = (hi == ALL1);
                    end else begin
                        lo_nxt[NARROW_W-1:0] = lo[NARROW_W-1:0] + N_ONE;
                    end
                end
            end
            TM_FULL16: begin
                if (step_lo) begin
                    {hi_nxt, lo_nxt} = {hi, lo} + ONE_W;
                    ovf_lo = (hi == ALL1) && (lo == ALL1);
                end
            end
            TM_RELOAD8: begin
                if (step_lo) begin
                    if (lo == ALL1) begin
                        lo_nxt = hi;
                        ovf_lo = 1'b1;
                    end else begin
                        lo_nxt = lo + ONE_B;
                    end
                end
            end
            TM_SPLIT8: begin
                if (SPLIT_OK) begin
                    if (step_lo) begin
                        lo_nxt = lo + ONE_B;
                        ovf_lo = (lo == ALL1);
                    end
                    if (step_hi) begin
                        hi_nxt = hi + ONE_B;
                        ovf_hi = (hi == ALL1);
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/dual_tmr_unit.sv
module dual_tmr_unit
    import tmr_pkg::*;
#(
    parameter int DW       = 8,
    parameter int DIV      = 12,
    parameter int NARROW_W = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    sfr_addr,
    input  logic          sfr_wr,
    input  logic [DW-1:0] sfr_wdata,
    output logic [DW-1:0] sfr_rdata,
    output logic          tf0_flag,
    output logic          tf1_flag
);
    logic [DW-1:0] ctrl_q, mode_q;
    logic [DW-1:0] t0lo_q, t0hi_q, t1lo_q, t1hi_q;
    logic [DW-1:0] ctrl_d;
    logic [DW-1:0] t0lo_n, t0hi_n, t1lo_n, t1hi_n;
    logic          tick;
    logic          t0_ovf_lo, t0_ovf_hi, t1_ovf_lo, t1_ovf_hi;
    logic          flag0_set, flag1_set;
    logic          split0;
    tmr_mode_e     mode0, mode1;

    tmr_prescaler #(.DIV(DIV)) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign mode0  = tmr_mode_e'(mode_q[1:0]);
    assign mode1  = tmr_mode_e'(mode_q[5:4]);
    assign split0 = (mode0 == TM_SPLIT8);

    tmr_step #(.DW(DW), .NARROW_W(NARROW_W), .SPLIT_OK(1'b1)) step0_i (
        .mode    (mode0),
        .step_lo (tick & ctrl_q[CTRL_RUN0]),
        .step_hi (tick & ctrl_q[CTRL_RUN1]),
        .lo      (t0lo_q),
        .hi      (t0hi_q),
        .lo_nxt  (t0lo_n),
        .hi_nxt  (t0hi_n),
        .ovf_lo  (t0_ovf_lo),
        .ovf_hi  (t0_ovf_hi)
    );

    tmr_step #(.DW(DW), .NARROW_W(NARROW_W), .SPLIT_OK(1'b0)) step1_i (
        .mode    (mode1),
        .step_lo (tick & (split0 | ctrl_q[CTRL_RUN1])),
        .step_hi (1'b0),
        .lo      (t1lo_q),
        .hi      (t1hi_q),
        .lo_nxt  (t1lo_n),
        .hi_nxt  (t1hi_n),
        .ovf_lo  (t1_ovf_lo),
        .ovf_hi  (t1_ovf_hi)
    );

    // flag sources: in split, timer 0's high byte owns flag 1
    assign flag0_set = t0_ovf_lo;
    assign flag1_set = split0 ? t0_ovf_hi : (t1_ovf_lo | t1_ovf_hi);

    always_comb begin
        ctrl_d = (sfr_wr && sfr_addr == ADDR_CTRL) ? sfr_wdata : ctrl_q;
        ctrl_d[CTRL_FLAG0] = ctrl_d[CTRL_FLAG0] | flag0_set;
        ctrl_d[CTRL_FLAG1] = ctrl_d[CTRL_FLAG1] | flag1_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
            t0lo_q <= '0;
            t0hi_q <= '0;
            t1lo_q <= '0;
            t1hi_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            mode_q <= (sfr_wr && sfr_addr == ADDR_MODE) ? sfr_wdata : mode_q;
            t0lo_q <= (sfr_wr && sfr_addr == ADDR_T0LO) ? sfr_wdata : t0lo_n;
            t0hi_q <= (sfr_wr && sfr_addr == ADDR_T0HI) ? sfr_wdata : t0hi_n;
            t1lo_q <= (sfr_wr && sfr_addr == ADDR_T1LO) ? sfr_wdata : t1lo_n;
            t1hi_q <= (sfr_wr && sfr_addr == ADDR_T1HI) ? sfr_wdata : t1hi_n;
        end
    end

    always_comb begin
        case (sfr_addr)
            ADDR_CTRL: sfr_rdata = ctrl_q;
            ADDR_MODE: sfr_rdata = mode_q;
            ADDR_T0LO: sfr_rdata = t0lo_q;
            ADDR_T1LO: sfr_rdata = t1lo_q;
            ADDR_T0HI: sfr_rdata = t0hi_q;
            ADDR_T1HI: sfr_rdata = t1hi_q;
            default:   sfr_rdata = '0;
        endcase
    end

    assign tf0_flag = ctrl_q[CTRL_FLAG0];
    assign tf1_flag = ctrl_q[CTRL_FLAG1];
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    sfr_addr,
    input logic          sfr_wr,
    input logic [DW-1:0] sfr_wdata,
    input logic          tick,
    input logic [DW-1:0] ctrl_q,
    input logic [DW-1:0] mode_q,
    input logic [DW-1:0] t0lo_q,
    input logic [DW-1:0] t0hi_q,
    input logic [DW-1:0] t1lo_q,
    input logic [DW-1:0] t1hi_q
);
    localparam logic [2*DW-1:0] ONE_W = (2*DW)'(1);

    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sfr_wr) |=> ($stable(t0lo_q) && $stable(t0hi_q) && $stable(t1lo_q) && $stable(t1hi_q)));

    assert_reload_from_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl_q[CTRL_RUN0] && mode_q[1:0] == 2'd2 && t0lo_q == '1 && !sfr_wr)
        |=> (t0lo_q == $past(t0hi_q)));

    assert_split_t1_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode_q[1:0] == 2'd3 && mode_q[5:4] == 2'd1 && !sfr_wr)
        |=> ({t1hi_q, t1lo_q} == $past({t1hi_q, t1lo_q}) + ONE_W));

    assert_t1_mode3_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[5:4] == 2'd3 && mode_q[1:0] != 2'd3 && !sfr_wr)
        |=> ($stable(t1lo_q) && $stable(t1hi_q)));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTRL_FLAG0] && !(sfr_wr && sfr_addr == ADDR_CTRL)) |=> ctrl_q[CTRL_FLAG0]);

    assert_wrap_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl_q[CTRL_RUN0] && mode_q[1:0] == 2'd1 && t0hi_q == '1 && t0lo_q == '1)
        |=> ctrl_q[CTRL_FLAG0]);

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_addr == ADDR_T0LO) |=> (t0lo_q == $past(sfr_wdata)));
endmodule

bind dual_tmr_unit tmr_unit_chk #(.DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .tick      (tick),
    .ctrl_q    (ctrl_q),
    .mode_q    (mode_q),
    .t0lo_q    (t0lo_q),
    .t0hi_q    (t0hi_q),
    .t1lo_q    (t1lo_q),
    .t1hi_q    (t1hi_q)
);

// File: tb/dual_tmr_unit_tb_top.sv
`timescale 1ns/1ps
module dual_tmr_unit_tb_top;
    localparam logic [7:0] A_CTRL = 8'h88;
    localparam logic [7:0] A_MODE = 8'h89;
    localparam logic [7:0] A_T0LO = 8'h8A;
    localparam logic [7:0] A_T1LO = 8'h8B;
    localparam logic [7:0] A_T0HI = 8'h8C;
    localparam logic [7:0] A_T1HI = 8'h8D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       tf0_flag, tf1_flag;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    dual_tmr_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_addr  (sfr_addr),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .tf0_flag  (tf0_flag),
        .tf1_flag  (tf1_flag)
    );

    // writes start just after a falling edge and take exactly one rising edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr  = a;
        sfr_wdata = d;
        sfr_wr    = 1'b1;
        @(negedge clk);
        #1;
        sfr_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        sfr_wr   = 1'b0;
        #1;
        d = sfr_rdata;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input int exp, input string tag);
        logic [7:0] v;
        rd(a, v);
        chk(tag, int'(v), exp);
    endtask

    // run for exactly k ticks: k*12 rising edges between start and stop writes
    task automatic run_ticks(input logic [7:0] runbits, input int k);
        logic [7:0] c;
        rd(A_CTRL, c);
        wr(A_CTRL, c | runbits);
        repeat (12 * k - 1) @(negedge clk);
        rd(A_CTRL, c);
        wr(A_CTRL, c & 8'hAF);
    endtask

    task automatic load(input logic [7:0] m, input logic [7:0] l0, input logic [7:0] h0,
                        input logic [7:0] l1, input logic [7:0] h1);
        wr(A_CTRL, 8'h00);
        wr(A_MODE, m);
        wr(A_T0LO, l0);
        wr(A_T0HI, h0);
        wr(A_T1LO, l1);
        wr(A_T1HI, h1);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        rd_chk(A_CTRL, 0, "R1 ctrl");
        rd_chk(A_MODE, 0, "R1 mode");
        rd_chk(A_T0LO, 0, "R1 t0lo");
        rd_chk(A_T0HI, 0, "R1 t0hi");
        rd_chk(A_T1LO, 0, "R1 t1lo");
        rd_chk(A_T1HI, 0, "R1 t1hi");
        chk("R1 flags", {30'd0, tf1_flag, tf0_flag}, 0);

        // R2 readback, unmapped, inert bits
        wr(A_MODE, 8'hCD);
        rd_chk(A_MODE, 8'hCD, "R2 mode readback");
        rd_chk(8'h90, 0, "R2 unmapped");
        wr(A_CTRL, 8'h0A);
        rd_chk(A_CTRL, 8'h0A, "R10 ctrl low storage");
        load(8'hCD, 8'h00, 8'h00, 8'h00, 8'h00);
        run_ticks(8'h10, 5);
        rd_chk(A_T0LO, 5, "R2 inert mode bits");

        // R3 run bit clear holds
        load(8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
        repeat (60) @(negedge clk);
        rd_chk(A_T0LO, 0, "R3 stopped hold");
        run_ticks(8'h10, 7);
        rd_chk(A_T0LO, 7, "R3 seven ticks");
        repeat (30) @(negedge clk);
        rd_chk(A_T0LO, 7, "R3 hold after stop");

        // R5 16-bit wrap, R10 sticky flag
        load(8'h01, 8'hFE, 8'hFF, 8'h00, 8'h00);
        run_ticks(8'h10, 3);
        rd_chk(A_T0LO, 1, "R5 wrap low");
        rd_chk(A_T0HI, 0, "R5 wrap high");
        chk("R5 flag port", int'(tf0_flag), 1);
        run_ticks(8'h10, 2);
        chk("R10 flag sticky", int'(tf0_flag), 1);
        wr(A_CTRL, 8'h00);
        chk("R10 flag cleared", int'(tf0_flag), 0);
        load(8'h01, 8'hFF, 8'h12, 8'h00, 8'h00);
        run_ticks(8'h10, 1);
        rd_chk(A_T0HI, 8'h13, "R5 carry high");
        rd_chk(A_T0LO, 0, "R5 carry low");

        // R4 13-bit sweep on timer 1
        for (int k = 28; k <= 40; k += 3) begin
            load(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
            run_ticks(8'h40, k);
            rd_chk(A_T1LO, k % 32, "R4 sweep low");
            rd_chk(A_T1HI, k / 32, "R4 sweep high");
        end
        load(8'h00, 8'hFE, 8'hFF, 8'h00, 8'h00);
        run_ticks(8'h10, 3);
        rd_chk(A_T0LO, 8'hE1, "R4 upper bits kept");
        rd_chk(A_T0HI, 0, "R4 high wrap");
        chk("R4 flag", int'(tf0_flag), 1);

        // R6 reload sweep
        for (int k = 1; k <= 16; k++) begin
            load(8'h02, 8'hF8, 8'hF8, 8'h00, 8'h00);
            run_ticks(8'h10, k);
            rd_chk(A_T0LO, 8'hF8 + (k % 8), "R6 reload low");
            chk("R6 reload flag", int'(tf0_flag), (k >= 8) ? 1 : 0);
        end
        rd_chk(A_T0HI, 8'hF8, "R6 high kept");

        // R7 split counters
        load(8'h03, 8'hFE, 8'h10, 8'h00, 8'h00);
        run_ticks(8'h10, 3);
        rd_chk(A_T0LO, 1, "R7 split low");
        rd_chk(A_T0HI, 8'h10, "R7 split high idle");
        chk("R7 split flags a", {30'd0, tf1_flag, tf0_flag}, 1);
        wr(A_CTRL, 8'h00);
        wr(A_T0HI, 8'hFF);
        run_ticks(8'h40, 2);
        rd_chk(A_T0HI, 1, "R7 split high");
        rd_chk(A_T0LO, 1, "R7 split low idle");
        chk("R7 split flags b", {30'd0, tf1_flag, tf0_flag}, 2);

        // R8 timer 1 free running while split
        load(8'h10, 8'h00, 8'h00, 8'h00, 8'h00);
        wr(A_MODE, 8'h13);
        repeat (12 * 9 - 1) @(negedge clk);
        wr(A_MODE, 8'h10);
        rd_chk(A_T1LO, 9, "R8 free count");
        repeat (24) @(negedge clk);
        rd_chk(A_T1LO, 9, "R8 stops when unsplit");
        load(8'h10, 8'h00, 8'h00, 8'hFF, 8'hFF);
        wr(A_MODE, 8'h13);
        repeat (12 * 2 - 1) @(negedge clk);
        wr(A_MODE, 8'h10);
        rd_chk(A_T1LO, 1, "R8 wrap low");
        rd_chk(A_T1HI, 0, "R8 wrap high");
        chk("R8 no flag", int'(tf1_flag), 0);

        // R9 timer 1 mode 3 holds
        load(8'h30, 8'h00, 8'h00, 8'h05, 8'hFF);
        run_ticks(8'h40, 4);
        rd_chk(A_T1LO, 5, "R9 hold low");
        rd_chk(A_T1HI, 8'hFF, "R9 hold high");
        chk("R9 no flag", int'(tf1_flag), 0);

        // R11 write on the tick edge
        load(8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
        wr(A_CTRL, 8'h10);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            rd(A_T0LO, v);
            if (v != 8'h00) break;
        end
        chk("R11 phase found", int'(v), 1);
        repeat (11) @(negedge clk);
        wr(A_T0LO, 8'h40);
        rd_chk(A_T0LO, 8'h40, "R11 write wins");
        repeat (11) @(negedge clk);
        rd_chk(A_T0LO, 8'h40, "R11 no late step");
        @(negedge clk);
        rd_chk(A_T0LO, 8'h41, "R11 next tick");
        wr(A_CTRL, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R3 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule